// File: doc/BRIEF.md
# Per-Port Statistics Snapshot Engine

This block keeps receive and transmit event counters for every port of a small switch and publishes them through a separate snapshot bank that software reads by address. The MAC side delivers one pulse per finished frame on each direction of each port, together with the frame length and a few qualifier flags. From these the block counts broadcast, multicast, pause and error frames. It sorts good-length frames into a seven-bucket size histogram, flags runts and oversize frames, and accumulates 64-bit byte totals. The event counters are 32 bits wide.

Software never reads the live counters. It writes a function code into a 32-bit control word. Code 3 copies every live counter into the snapshot bank. Code 1 clears both the live and the snapshot counters. Any other code starts nothing. While an operation runs, a busy flag in the same word is set. The engine works through the ports one per cycle, so busy stays high for exactly `NUM_PORTS` cycles.

The sequencer has three states: `ST_IDLE`, `ST_CAPTURE` and `ST_FLUSH`. It makes these transitions:
- idle to capture, on an accepted code-3 write;
- idle to flush, on an accepted code-1 write;
- capture or flush stepping to the next port, when the swept port is not the last;
- capture or flush back to idle, when the last port has been swept.

Top module: `mib_capture_engine`

## Requirements
- R1: After reset every snapshot word reads 0 and the control word reads 0.
- R2: The control word holds the function code in bits [26:24], busy in bit 17, a stored half-full capture enable in bit 16 and a stored 16-bit timer value in bits [15:0]. An accepted write updates bits 16 and [15:0] so that they read back the written values; all other bits read 0.
- R3: An accepted capture write (code 3) sets busy and shows code 3 from the next cycle for exactly NUM_PORTS cycles, after which busy and the code both read 0.
- R4: Capture copies each port's live counters into its snapshot, port 0 first and one port per cycle; live counting continues, and a snapshot word is unchanged between operations.
- R5: A flush (code 1) has the same busy timing as capture and leaves every live and snapshot counter of every port at 0.
- R6: A control write while busy is set has no effect on the code, enable, timer or running operation.
- R7: Codes other than 1 and 3 start no operation: busy stays 0 and the code field reads 0, while the enable and timer fields are still written.
- R8: Snapshot words sit at 0x20000 + port*0x100 + 4*index, with address bits [1:0] ignored. Indices 0-12 are receive counters: broadcast, multicast, pause, FCS error, runt, oversize, then buckets 0-6. Indices 13-24 are transmit counters: broadcast, multicast, pause, collision, oversize, then buckets 0-6. Indices 25/26, 27/28 and 29/30 are the low/high words of receive good bytes, receive bad bytes and transmit bytes. Every other address reads 0.
- R9: Histogram buckets 0-6 cover the lengths 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518 and 1519-MAX_FRAME (default 1536).
- R10: A receive frame is counted under the flags it carries: flag bit 0 is broadcast, bit 1 is multicast, bit 2 is pause and bit 3 is FCS error. It also goes into exactly one of runt (length < 64), oversize (length > MAX_FRAME) or its size bucket. Its length is added to good bytes when it has no FCS error and is between 64 and MAX_FRAME; otherwise the length is added to bad bytes.
- R11: A frame pulse on a port in the cycle that port is flushed is lost. A pulse in the cycle that port is captured reaches the live counter only.
- R12: A transmit frame is counted under the flags it carries: bit 0 is broadcast, bit 1 is multicast, bit 2 is pause and bit 3 is collision. Lengths above MAX_FRAME count as oversize, lengths below 64 fall into bucket 0, and every length is added to transmit bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_rd_data | output | 32 | Control word readback |
| rx_fire | input | NUM_PORTS | Receive frame done, one bit per port |
| rx_flags | input | 4*NUM_PORTS | Receive qualifiers, 4 bits per port |
| rx_len | input | LEN_W*NUM_PORTS | Receive frame length per port |
| tx_fire | input | NUM_PORTS | Transmit frame done, one bit per port |
| tx_flags | input | 4*NUM_PORTS | Transmit qualifiers, 4 bits per port |
| tx_len | input | LEN_W*NUM_PORTS | Transmit frame length per port |
| rd_addr | input | ADDR_W | Snapshot read address |
| rd_data | output | 32 | Snapshot word at rd_addr, combinational |

## Verification
The assertions assume that control writes and frame pulses are synchronous, free of X after reset, and that frame lengths fit in LEN_W bits. They also assume that sweep strobes come only from the sequencer, so capture and clear never hit the same port together. The stimulus drives every input half a cycle away from the sampling edge. It keeps lengths between 40 and 1600 bytes and issues writes during busy on purpose, so that the ignore path is exercised. Dense random traffic ensures that frame pulses land in the cycles where individual ports are swept.

// File: rtl/mib_pkg.sv
`timescale 1ns/1ps
package mib_pkg;

    // data widths
    localparam int CTL_W      = 32;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 32;
    localparam int BYTE_W     = 64;
    localparam int FLAG_W     = 4;

    // counter set per port
    localparam int NUM_BUCKET = 7;
    localparam int NUM_EVT    = 25;
    localparam int NUM_BYTE   = 3;

    // event counter indices (word index = counter index)
    localparam int IX_RX_BCAST = 0;
    localparam int IX_RX_MCAST = 1;
    localparam int IX_RX_PAUSE = 2;
    localparam int IX_RX_FCS   = 3;
    localparam int IX_RX_RUNT  = 4;
    localparam int IX_RX_OVER  = 5;
    localparam int IX_RX_HIST  = 6;
    localparam int IX_TX_BCAST = 13;
    localparam int IX_TX_MCAST = 14;
    localparam int IX_TX_PAUSE = 15;
    localparam int IX_TX_COLL  = 16;
    localparam int IX_TX_OVER  = 17;
    localparam int IX_TX_HIST  = 18;

    // byte counter indices
    localparam int BX_RX_GOOD  = 0;
    localparam int BX_RX_BAD   = 1;
    localparam int BX_TX       = 2;

    // qualifier flag bits
    localparam int FL_BCAST    = 0;
    localparam int FL_MCAST    = 1;
    localparam int FL_PAUSE    = 2;
    localparam int FL_ERR      = 3;

    // control word layout
    localparam int FN_LSB      = 24;
    localparam int FN_W        = 3;
    localparam int BUSY_BIT    = 17;
    localparam int HALF_BIT    = 16;
    localparam int TIMER_W     = 16;

    localparam logic [FN_W-1:0] FN_NOP     = 3'd0;
    localparam logic [FN_W-1:0] FN_FLUSH   = 3'd1;
    localparam logic [FN_W-1:0] FN_CAPTURE = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FLUSH   = 2'd2
    } sweep_state_e;

    // size histogram bucket for a frame length (lengths up to 64 map to 0)
    function automatic int unsigned size_bucket(input int unsigned len);
        if (len <= 64)        return 0;
        else if (len <= 127)  return 1;
        else if (len <= 255)  return 2;
        else if (len <= 511)  return 3;
        else if (len <= 1023) return 4;
        else if (len <= 1518) return 5;
        else                  return 6;
    endfunction

endpackage

// File: rtl/mib_ctl_fsm.sv
`timescale 1ns/1ps
module mib_ctl_fsm
    import mib_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTL_W-1:0]     wr_data,
    output logic [CTL_W-1:0]     ctl_rd_data,
    output logic [NUM_PORTS-1:0] cap_port,
    output logic [NUM_PORTS-1:0] clr_port
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);

    sweep_state_e        state_q, state_d;
    logic [IDX_W-1:0]    idx_q, idx_d;
    logic [FN_W-1:0]     func_q;
    logic [TIMER_W-1:0]  timer_q;
    logic                half_q;
    logic                busy;
    logic                accept;
    logic                last_step;
    logic [FN_W-1:0]     code;
    logic                unused_wr_bits;

    assign code           = wr_data[FN_LSB +: FN_W];
    assign accept         = wr_en && (state_q == ST_IDLE);
    assign last_step      = (state_q != ST_IDLE) && (idx_q == LAST_IDX);
    assign unused_wr_bits = ^{wr_data[CTL_W-1:FN_LSB+FN_W], wr_data[FN_LSB-1:HALF_BIT+1]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    idx_d = '0;
                    if (code == FN_CAPTURE)    state_d = ST_CAPTURE;
                    else if (code == FN_FLUSH) state_d = ST_FLUSH;
                end
            end
            ST_CAPTURE, ST_FLUSH: begin
                if (idx_q == LAST_IDX) state_d = ST_IDLE;
                else                   idx_d   = idx_q + IDX_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q  <= FN_NOP;
            timer_q <= '0;
            half_q  <= 1'b0;
        end else if (accept) begin
            timer_q <= wr_data[TIMER_W-1:0];
            half_q  <= wr_data[HALF_BIT];
            func_q  <= ((code == FN_CAPTURE) || (code == FN_FLUSH)) ? code : FN_NOP;
        end else if (last_step) begin
            func_q  <= FN_NOP;
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        cap_port = '0;
        clr_port = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CAPTURE: begin
                busy = 1'b1;
                for (int p = 0; p < NUM_PORTS; p++)
                    cap_port[p] = (idx_q == IDX_W'(p));
            end
            ST_FLUSH: begin
                busy = 1'b1;
                for (int p = 0; p < NUM_PORTS; p++)
                    clr_port[p] = (idx_q == IDX_W'(p));
            end
            default: busy = 1'b0;
        endcase
        ctl_rd_data                       = '0;
        ctl_rd_data[FN_LSB +: FN_W]       = func_q;
        ctl_rd_data[BUSY_BIT]             = busy;
        ctl_rd_data[HALF_BIT]             = half_q;
        ctl_rd_data[TIMER_W-1:0]          = timer_q;
    end

    // R3: busy lasts exactly one sweep
    a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx_q == LAST_IDX) |=> !busy);
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx_q != LAST_IDX) |=> busy);
    // R6: writes during busy leave the stored fields alone
    a_r6_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(timer_q) && $stable(half_q)));
    // R4 / R5: at most one port swept, never both operations
    a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_port, clr_port}));

endmodule

// File: rtl/mib_port_bank.sv
`timescale 1ns/1ps
module mib_port_bank
    import mib_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1536
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rx_fire,
    input  logic [FLAG_W-1:0]                   rx_flags,
    input  logic [LEN_W-1:0]                    rx_len,
    input  logic                                tx_fire,
    input  logic [FLAG_W-1:0]                   tx_flags,
    input  logic [LEN_W-1:0]                    tx_len,
    input  logic                                cap,
    input  logic                                clr,
    output logic [NUM_EVT-1:0][CNT_W-1:0]       snap_evt,
    output logic [NUM_BYTE-1:0][BYTE_W-1:0]     snap_byte
);

    logic [NUM_EVT-1:0][CNT_W-1:0]   live_evt;
    logic [NUM_BYTE-1:0][BYTE_W-1:0] live_byte;
    logic [NUM_EVT-1:0]              inc;
    logic [NUM_BYTE-1:0][BYTE_W-1:0] add_amt;

    // classification of this cycle's frames
    always_comb begin
        int unsigned rl;
        int unsigned tl;
        int unsigned rb;
        int unsigned tb;
        logic        good;
        inc     = '0;
        add_amt = '0;
        rl      = 32'(rx_len);
        tl      = 32'(tx_len);
        rb      = size_bucket(rl);
        tb      = size_bucket(tl);
        good    = 1'b0;
        if (rx_fire) begin
            inc[IX_RX_BCAST] = rx_flags[FL_BCAST];
            inc[IX_RX_MCAST] = rx_flags[FL_MCAST];
            inc[IX_RX_PAUSE] = rx_flags[FL_PAUSE];
            inc[IX_RX_FCS]   = rx_flags[FL_ERR];
            if (rl < 64)                inc[IX_RX_RUNT] = 1'b1;
            else if (rl > MAX_FRAME)    inc[IX_RX_OVER] = 1'b1;
            else begin
                for (int unsigned b = 0; b < NUM_BUCKET; b++)
                    if (rb == b) inc[IX_RX_HIST + b] = 1'b1;
            end
            good = !rx_flags[FL_ERR] && (rl >= 64) && (rl <= MAX_FRAME);
            if (good) add_amt[BX_RX_GOOD] = BYTE_W'(rx_len);
            else      add_amt[BX_RX_BAD]  = BYTE_W'(rx_len);
        end
        if (tx_fire) begin
            inc[IX_TX_BCAST] = tx_flags[FL_BCAST];
            inc[IX_TX_MCAST] = tx_flags[FL_MCAST];
            inc[IX_TX_PAUSE] = tx_flags[FL_PAUSE];
            inc[IX_TX_COLL]  = tx_flags[FL_ERR];
            if (tl > MAX_FRAME) inc[IX_TX_OVER] = 1'b1;
            else begin
                for (int unsigned b = 0; b < NUM_BUCKET; b++)
                    if (tb == b) inc[IX_TX_HIST + b] = 1'b1;
            end
            add_amt[BX_TX] = BYTE_W'(tx_len);
        end
    end

    // live and snapshot event counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_evt <= '0;
            snap_evt <= '0;
        end else if (clr) begin
            live_evt <= '0;
            snap_evt <= '0;
        end else begin
            if (cap) snap_evt <= live_evt;
            for (int i = 0; i < NUM_EVT; i++)
                if (inc[i]) live_evt[i] <= live_evt[i] + CNT_W'(1);
        end
    end

    // live and snapshot byte counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_byte <= '0;
            snap_byte <= '0;
        end else if (clr) begin
            live_byte <= '0;
            snap_byte <= '0;
        end else begin
            if (cap) snap_byte <= live_byte;
            for (int i = 0; i < NUM_BYTE; i++)
                live_byte[i] <= live_byte[i] + add_amt[i];
        end
    end

    // R5 / R11: a cleared port holds zero in both banks next cycle
    a_r5_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live_evt == '0 && snap_evt == '0 && live_byte == '0 && snap_byte == '0));
    // R4: capture copies the pre-edge live values
    a_r4_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (snap_evt == $past(live_evt) && snap_byte == $past(live_byte)));
    // R4: snapshot frozen outside sweeps
    a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !clr) |=> ($stable(snap_evt) && $stable(snap_byte)));

endmodule

// File: rtl/mib_read_mux.sv
`timescale 1ns/1ps
module mib_read_mux
    import mib_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int ADDR_W    = 18,
    parameter int BASE      = 'h20000,
    parameter int STRIDE_LG = 8
) (
    input  logic [ADDR_W-1:0]                                  rd_addr,
    input  logic [NUM_PORTS-1:0][NUM_EVT-1:0][CNT_W-1:0]       snap_evt,
    input  logic [NUM_PORTS-1:0][NUM_BYTE-1:0][BYTE_W-1:0]     snap_byte,
    output logic [WORD_W-1:0]                                  rd_data
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_PORTS << STRIDE_LG);

    logic [ADDR_W-1:0]    rel;
    logic [ADDR_W-1:0]    port_sel;
    logic [STRIDE_LG-1:0] word_sel;
    logic                 in_range;

    assign rel      = rd_addr - BASE_A;
    assign in_range = (rd_addr >= BASE_A) && (rel < SPAN_A);
    assign port_sel = rel >> STRIDE_LG;
    assign word_sel = rel[STRIDE_LG-1:0] >> 2;

    always_comb begin
        rd_data = '0;
        if (in_range) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_sel == ADDR_W'(p)) begin
                    for (int w = 0; w < NUM_EVT; w++)
                        if (word_sel == STRIDE_LG'(w)) rd_data = snap_evt[p][w];
                    for (int b = 0; b < NUM_BYTE; b++) begin
                        if (word_sel == STRIDE_LG'(NUM_EVT + 2*b))
                            rd_data = snap_byte[p][b][WORD_W-1:0];
                        if (word_sel == STRIDE_LG'(NUM_EVT + 2*b + 1))
                            rd_data = snap_byte[p][b][BYTE_W-1:WORD_W];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mib_capture_engine.sv
`timescale 1ns/1ps
module mib_capture_engine
    import mib_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1536,
    parameter int ADDR_W    = 18,
    parameter int BASE      = 'h20000,
    parameter int STRIDE_LG = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_wr_en,
    input  logic [31:0]                  ctl_wr_data,
    output logic [31:0]                  ctl_rd_data,
    input  logic [NUM_PORTS-1:0]         rx_fire,
    input  logic [4*NUM_PORTS-1:0]       rx_flags,
    input  logic [LEN_W*NUM_PORTS-1:0]   rx_len,
    input  logic [NUM_PORTS-1:0]         tx_fire,
    input  logic [4*NUM_PORTS-1:0]       tx_flags,
    input  logic [LEN_W*NUM_PORTS-1:0]   tx_len,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [31:0]                  rd_data
);

    logic [NUM_PORTS-1:0]                              cap_port;
    logic [NUM_PORTS-1:0]                              clr_port;
    logic [NUM_PORTS-1:0][NUM_EVT-1:0][CNT_W-1:0]      snap_evt;
    logic [NUM_PORTS-1:0][NUM_BYTE-1:0][BYTE_W-1:0]    snap_byte;

    mib_ctl_fsm #(
        .NUM_PORTS (NUM_PORTS)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctl_wr_en),
        .wr_data     (ctl_wr_data),
        .ctl_rd_data (ctl_rd_data),
        .cap_port    (cap_port),
        .clr_port    (clr_port)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mib_port_bank #(
            .LEN_W     (LEN_W),
            .MAX_FRAME (MAX_FRAME)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_fire   (rx_fire[p]),
            .rx_flags  (rx_flags[p*FLAG_W +: FLAG_W]),
            .rx_len    (rx_len[p*LEN_W +: LEN_W]),
            .tx_fire   (tx_fire[p]),
            .tx_flags  (tx_flags[p*FLAG_W +: FLAG_W]),
            .tx_len    (tx_len[p*LEN_W +: LEN_W]),
            .cap       (cap_port[p]),
            .clr       (clr_port[p]),
            .snap_evt  (snap_evt[p]),
            .snap_byte (snap_byte[p])
        );
    end

    mib_read_mux #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .BASE      (BASE),
        .STRIDE_LG (STRIDE_LG)
    ) u_rd (
        .rd_addr   (rd_addr),
        .snap_evt  (snap_evt),
        .snap_byte (snap_byte),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sim_mib_capture_engine.sv
`timescale 1ns/1ps
module sim_mib_capture_engine;

    localparam int P  = 6;
    localparam int LW = 11;
    localparam int AW = 18;
    localparam int NW = 28;   // 25 event + 3 byte counters

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr_en = 1'b0;
    logic [31:0]      ctl_wr_data = '0;
    logic [31:0]      ctl_rd_data;
    logic [P-1:0]     rx_fire = '0, tx_fire = '0;
    logic [4*P-1:0]   rx_flags = '0, tx_flags = '0;
    logic [LW*P-1:0]  rx_len = '0, tx_len = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [31:0]      rd_data;

    always #2 clk = ~clk;   // 250 MHz

    mib_capture_engine u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_rd_data(ctl_rd_data), .rx_fire(rx_fire), .rx_flags(rx_flags), .rx_len(rx_len),
        .tx_fire(tx_fire), .tx_flags(tx_flags), .tx_len(tx_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    longint unsigned m_live [P][NW];
    longint unsigned m_snap [P][NW];
    int              m_state, m_idx, m_func, m_half, m_timer;

    int    n_checks = 0, n_fail = 0;
    bit    finished = 1'b0;
    bit    traffic_on = 1'b0;
    bit    directed = 1'b0;
    int    density = 4;
    string cur_req = "R1";

    function automatic int bucket_of(int len);
        if (len <= 64) return 0;
        if (len <= 127) return 1;
        if (len <= 255) return 2;
        if (len <= 511) return 3;
        if (len <= 1023) return 4;
        if (len <= 1518) return 5;
        return 6;
    endfunction

    function automatic void model_reset();
        for (int p = 0; p < P; p++)
            for (int w = 0; w < NW; w++) begin m_live[p][w] = 0; m_snap[p][w] = 0; end
        m_state = 0; m_idx = 0; m_func = 0; m_half = 0; m_timer = 0;
    endfunction

    function automatic void model_step();
        int lost = -1;
        if (m_state == 0) begin
            if (ctl_wr_en) begin
                int code = int'(ctl_wr_data[26:24]);
                m_timer = int'(ctl_wr_data[15:0]);
                m_half  = int'(ctl_wr_data[16]);
                if (code == 3)      begin m_state = 1; m_idx = 0; m_func = 3; end
                else if (code == 1) begin m_state = 2; m_idx = 0; m_func = 1; end
                else m_func = 0;
            end
        end else begin
            for (int w = 0; w < NW; w++) begin
                if (m_state == 1) m_snap[m_idx][w] = m_live[m_idx][w];
                else begin m_snap[m_idx][w] = 0; m_live[m_idx][w] = 0; end
            end
            if (m_state == 2) lost = m_idx;
            if (m_idx == P-1) begin m_state = 0; m_func = 0; end
            else m_idx++;
        end
        for (int p = 0; p < P; p++) begin
            if (p == lost) continue;
            if (rx_fire[p]) begin
                logic [3:0] f = rx_flags[p*4 +: 4];
                int len = int'(rx_len[p*LW +: LW]);
                for (int k = 0; k < 4; k++) if (f[k]) m_live[p][k]++;
                if (len < 64) m_live[p][4]++;
                else if (len > 1536) m_live[p][5]++;
                else m_live[p][6 + bucket_of(len)]++;
                if (!f[3] && len >= 64 && len <= 1536) m_live[p][25] += longint'(len);
                else m_live[p][26] += longint'(len);
            end
            if (tx_fire[p]) begin
                logic [3:0] f = tx_flags[p*4 +: 4];
                int len = int'(tx_len[p*LW +: LW]);
                for (int k = 0; k < 4; k++) if (f[k]) m_live[p][13 + k]++;
                if (len > 1536) m_live[p][17]++;
                else m_live[p][18 + bucket_of(len)]++;
                m_live[p][27] += longint'(len);
            end
        end
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int ai = int'(a);
        int p, w;
        longint unsigned v;
        if (ai < 'h20000 || ai >= 'h20000 + P*256) return 32'h0;
        p = (ai - 'h20000) >> 8;
        w = (ai & 255) >> 2;
        if (w < 25) return m_snap[p][w][31:0];
        if (w < 31) begin
            v = m_snap[p][25 + (w-25)/2];
            return ((w-25) % 2 == 1) ? v[63:32] : v[31:0];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // ---------------- comparison every clock ----------------
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] exp_ctl, exp_rd;
            exp_ctl = '0;
            exp_ctl[26:24] = 3'(m_func);
            exp_ctl[17]    = (m_state != 0);
            exp_ctl[16]    = m_half[0];
            exp_ctl[15:0]  = 16'(m_timer);
            n_checks++;
            if (ctl_rd_data !== exp_ctl) begin
                n_fail++;
                $display("FAIL %s control word: actual %h expected %h", cur_req, ctl_rd_data, exp_ctl);
            end
            exp_rd = model_read(rd_addr);
            n_checks++;
            if (rd_data !== exp_rd) begin
                n_fail++;
                $display("FAIL %s read @%h: actual %h expected %h", cur_req, rd_addr, rd_data, exp_rd);
            end
        end
    end

    // ---------------- stimulus ----------------
    always @(negedge clk) begin
        #1;
        if (!directed) begin
            for (int p = 0; p < P; p++) begin
                bit rf = traffic_on && (($urandom % density) == 0);
                bit tf = traffic_on && (($urandom % density) == 0);
                rx_fire[p] = rf;
                tx_fire[p] = tf;
                rx_flags[p*4 +: 4] = rf ? 4'($urandom) : 4'h0;
                tx_flags[p*4 +: 4] = tf ? 4'($urandom) : 4'h0;
                rx_len[p*LW +: LW] = rf ? LW'($urandom_range(1600, 40)) : '0;
                tx_len[p*LW +: LW] = tf ? LW'($urandom_range(1600, 40)) : '0;
            end
        end
    end

    function automatic logic [31:0] mk_ctl(int code, int half, int timer);
        logic [31:0] v = '0;
        v[26:24] = 3'(code);
        v[16]    = half[0];
        v[15:0]  = 16'(timer);
        return v;
    endfunction

    task automatic ctl_write(logic [31:0] d);
        @(negedge clk); #1;
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk); #1;
        ctl_wr_en = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_sweep(int first, int last);
        for (int p = first; p <= last; p++)
            for (int w = 0; w < 32; w++) begin
                @(negedge clk); #1;
                rd_addr = AW'('h20000 + p*256 + w*4 + (w % 4));
            end
        @(negedge clk);
    endtask

    task automatic send_frame(int p, logic [3:0] rf, logic [3:0] tf, int len);
        @(negedge clk); #1;
        rx_fire = '0; tx_fire = '0;
        rx_fire[p] = 1'b1; tx_fire[p] = 1'b1;
        rx_flags[p*4 +: 4] = rf; tx_flags[p*4 +: 4] = tf;
        rx_len[p*LW +: LW] = LW'(len); tx_len[p*LW +: LW] = LW'(len);
    endtask

    initial begin
        int lens [16] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 1536, 1537, 40};
        void'($urandom(32'd11));
        wait_cycles(3);
        @(negedge clk); #1; rst_n = 1'b1;

        cur_req = "R1";   // reset state: all snapshot words and control read zero
        read_sweep(0, 1);

        cur_req = "R2";   // field layout and readback of enable/timer
        ctl_write(mk_ctl(0, 1, 'hABCD));
        wait_cycles(2);

        cur_req = "R7";   // unused codes start nothing, fields still written
        ctl_write(mk_ctl(2, 0, 'h1111));
        wait_cycles(2);
        ctl_write(mk_ctl(5, 1, 'h2222));
        wait_cycles(2);
        ctl_write(mk_ctl(7, 0, 'h3333));
        wait_cycles(2);

        cur_req = "R3";   // capture busy window
        traffic_on = 1'b1;
        wait_cycles(300);
        ctl_write(mk_ctl(3, 1, 'h0042));
        cur_req = "R6";   // write during busy is ignored
        ctl_write(mk_ctl(1, 0, 'h1234));
        wait_cycles(8);

        cur_req = "R4";   // snapshot frozen while live keeps counting
        read_sweep(0, P-1);

        cur_req = "R11";  // dense traffic across capture and flush sweeps
        density = 1;
        wait_cycles(50);
        ctl_write(mk_ctl(3, 0, 'h0001));
        wait_cycles(8);
        read_sweep(0, 1);
        cur_req = "R5";   // flush clears everything, events in swept cycle lost
        ctl_write(mk_ctl(1, 0, 'h0002));
        wait_cycles(8);
        density = 3;
        wait_cycles(100);
        ctl_write(mk_ctl(3, 0, 'h0003));
        wait_cycles(8);
        read_sweep(0, P-1);

        cur_req = "R9";   // bucket boundaries on port 2, after a clean flush
        traffic_on = 1'b0;
        ctl_write(mk_ctl(1, 0, 0));
        wait_cycles(8);
        directed = 1'b1;
        foreach (lens[i]) send_frame(2, 4'h0, 4'h0, lens[i]);
        cur_req = "R10";  // receive flags, FCS error, good/bad bytes
        send_frame(2, 4'h9, 4'h0, 100);
        send_frame(2, 4'h6, 4'h0, 1600);
        cur_req = "R12";  // transmit flags and collision
        send_frame(2, 4'h0, 4'hF, 70);
        send_frame(2, 4'h0, 4'h8, 30);
        @(negedge clk); #1;
        rx_fire = '0; tx_fire = '0;
        directed = 1'b0;
        ctl_write(mk_ctl(3, 0, 0));
        wait_cycles(8);
        cur_req = "R9";
        read_sweep(2, 2);

        cur_req = "R8";   // addresses outside the map
        foreach (lens[i]) begin
            logic [AW-1:0] odd [6] = '{AW'('h1FFFC), AW'('h20600), AW'('h2007C),
                                      AW'('h3FFFF), AW'('h00000), AW'('h201FC)};
            if (i < 6) begin
                @(negedge clk); #1; rd_addr = odd[i];
            end
        end
        wait_cycles(2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL R3 watchdog: actual still running, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule